// File: doc/BRIEF.md
# Core Module System Control Register Bank

This block is the 32-bit control and identification register file of a processor core module. A processor reaches it over a simple word-indexed bus: one strobe, one write flag, a word index and a data word. Read data is registered and comes back in the cycle after the strobe, together with a one-cycle error flag for accesses that hit nothing.

The bank returns fixed identity and status words. It keeps two clock-oscillator words that accept writes only while a 16-bit unlock key sits in the lock word, plus SDRAM configuration and init words. Two flag words have separate set and clear indices. A control word drives the boot-memory remap, a green LED and a one-cycle board-reset request. A small interrupt section has one software-driven raw bit, separate IRQ and FIQ enable masks and registered IRQ and FIQ request outputs. A read-only window returns the bytes of the memory module's serial-presence-detect table. The installed memory size is a parameter that sets both the SDRAM size code and SPD byte 31.

Top module: `sysctl_bank`

## Requirements
- R1: A read of index 0 returns 0x411A3001, index 4 returns 0x00100000 and index 1 returns 0; read data appears on bus_rdata in the cycle after the read strobe and holds until the next read.
- R2: A write to the lock word (index 5) stores only wdata[15:0]; a read returns 0x0001A05F while the stored value is 0xA05F, and the stored value zero-extended otherwise.
- R3: Writes to the oscillator word (index 2) and the auxiliary oscillator word (index 7) change them only while the lock word holds 0xA05F; other writes leave them unchanged.
- R4: After reset the oscillator reads 0x01000048, the auxiliary oscillator 0x0007FEFF, the init word (index 9) 0x00000112 and the SDRAM word (index 8) 0x00011122 ORed with a size code of 0x10 (MEM_MB at least 256), 0x0C (at least 128), 0x08 (at least 64), 0x04 (at least 32) or 0; indices 8 and 9 take written values in full.
- R5: A write to index 12 ORs wdata into the flag word read at index 12, a write to index 13 clears the written bits; the non-volatile flag word works the same at indices 14 (set, read) and 15 (clear); both reset to 0.
- R6: A read of index 64+k returns SPD byte k zero-extended for k from 0 to 31, where byte 0 is 128, byte 2 is 4 and byte 31 is 64, 32, 16, 4 or 2 for the same MEM_MB bands as R4; indices 96 to 127 read 0.
- R7: A write to the control word (index 3) with wdata[3] set raises board_rst_o for exactly the following cycle; the word stores wdata with bit 3 cleared and resets to 0, remap_o is the inverse of its bit 2 and led_o equals its bit 0.
- R8: Raw interrupt bit 0 is set by a write to index 20 and cleared by a write to index 21, each only when wdata[0] is 1; index 20 reads raw bit 0, indices 17 and 25 read the raw word, all other raw bits are 0.
- R9: IRQ enables are ORed in at index 18 (also read there) and cleared at 19, FIQ enables at 26 (read) and 27; index 16 reads raw AND IRQ enables, index 24 raw AND FIQ enables.
- R10: irq_o and fiq_o are registered: they show whether raw AND the respective enables is non-zero one cycle after the write that changed the state.
- R11: Indices 32 to 35 read 0, accept writes without effect and never raise bus_err.
- R12: Any other read index, and any write to an index not listed as writable above, raises bus_err for one cycle, returns 0 on a read and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_widx | input | ADDR_W | Word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle error for an unmapped access |
| remap_o | output | 1 | Boot-memory remap active |
| led_o | output | 1 | Green LED |
| board_rst_o | output | 1 | One-cycle board-reset request |
| irq_o | output | 1 | Registered IRQ request |
| fiq_o | output | 1 | Registered FIQ request |

## Verification
The bench tries oscillator writes with the lock holding a wrong key and then the right one; a bank that ignored the key would read back the rejected data, and one that compared all 32 written lock bits would stay locked after a key with junk in the upper half. It clears flag bits through the clear index and checks that the other flag word is untouched, which catches a swapped or merged pair. It times irq_o and fiq_o against the write edge and checks that board_rst_o lasts one cycle and that bit 3 does not stick in the control word, and it probes both ends of the SPD window, the voltage indices and a write to a read-only index, where a wrong decode would either raise a false error or miss a real one.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

   // word indices the bus decoder uses
   localparam int unsigned IX_IDENT   = 0;
   localparam int unsigned IX_CPUINFO = 1;
   localparam int unsigned IX_OSC     = 2;
   localparam int unsigned IX_CTRL    = 3;
   localparam int unsigned IX_STAT    = 4;
   localparam int unsigned IX_LOCK    = 5;
   localparam int unsigned IX_AUXOSC  = 7;
   localparam int unsigned IX_SDCFG   = 8;
   localparam int unsigned IX_INIT    = 9;
   localparam int unsigned IX_FLG_SET = 12;
   localparam int unsigned IX_FLG_CLR = 13;
   localparam int unsigned IX_NVF_SET = 14;
   localparam int unsigned IX_NVF_CLR = 15;
   localparam int unsigned IX_IRQ_ST  = 16;
   localparam int unsigned IX_RAW_A   = 17;
   localparam int unsigned IX_IEN_SET = 18;
   localparam int unsigned IX_IEN_CLR = 19;
   localparam int unsigned IX_SW_SET  = 20;
   localparam int unsigned IX_SW_CLR  = 21;
   localparam int unsigned IX_FIQ_ST  = 24;
   localparam int unsigned IX_RAW_B   = 25;
   localparam int unsigned IX_FEN_SET = 26;
   localparam int unsigned IX_FEN_CLR = 27;
   localparam int unsigned IX_VOLT_LO = 32;
   localparam int unsigned IX_VOLT_HI = 35;
   localparam int unsigned IX_SPD_LO  = 64;
   localparam int unsigned SPD_USED   = 32;
   localparam int unsigned IX_SPD_HI  = 127;

   localparam logic [31:0] IDENT_WORD = 32'h411A_3001;
   localparam logic [31:0] STAT_WORD  = 32'h0010_0000;
   localparam logic [31:0] OSC_RST    = 32'h0100_0048;
   localparam logic [31:0] AUXOSC_RST = 32'h0007_FEFF;
   localparam logic [31:0] SDCFG_BASE = 32'h0001_1122;
   localparam logic [31:0] INIT_RST   = 32'h0000_0112;
   localparam logic [31:0] UNLOCK_RD  = 32'h0001_A05F;

   // number of set/clear words held in the bank
   localparam int unsigned N_SC    = 4;
   localparam int unsigned SC_FLG  = 0;
   localparam int unsigned SC_NVF  = 1;
   localparam int unsigned SC_IEN  = 2;
   localparam int unsigned SC_FEN  = 3;

   function automatic logic [31:0] size_code(int unsigned mb);
      if (mb >= 256)      return 32'h10;
      else if (mb >= 128) return 32'h0C;
      else if (mb >= 64)  return 32'h08;
      else if (mb >= 32)  return 32'h04;
      else                return 32'h00;
   endfunction

   function automatic logic [7:0] size_byte(int unsigned mb);
      if (mb >= 256)      return 8'd64;
      else if (mb >= 128) return 8'd32;
      else if (mb >= 64)  return 8'd16;
      else if (mb >= 32)  return 8'd4;
      else                return 8'd2;
   endfunction

   function automatic logic [7:0] spd_byte(int unsigned k, int unsigned mb);
      case (k)
         0: return 8'd128;  1: return 8'd8;    2: return 8'd4;    3: return 8'd11;
         4: return 8'd9;    5: return 8'd1;    6: return 8'd64;   8: return 8'd2;
         9: return 8'hA0;   10: return 8'hA0;  13: return 8'd8;   15: return 8'd1;
         16: return 8'h0E;  17: return 8'd4;   18: return 8'h1C;  19: return 8'd1;
         20: return 8'd2;   21: return 8'h20;  22: return 8'hC0;  27: return 8'h30;
         28: return 8'h28;  29: return 8'h30;  30: return 8'h28;
         31: return size_byte(mb);
         default: return 8'd0;
      endcase
   endfunction

endpackage

// File: rtl/sysctl_lock.sv
module sysctl_lock #(
   parameter int unsigned KEY_W = 16,
   parameter logic [KEY_W-1:0] KEY = 16'hA05F
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [KEY_W-1:0] wdata,
   output logic [KEY_W-1:0] key_q,
   output logic             unlocked
);

   always_ff @(posedge clk) begin
      if (!rst_n)  key_q <= '0;
      else if (we) key_q <= wdata;
   end

   assign unlocked = (key_q == KEY);

   // R2: only the written low half is held
   p_lock_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> key_q == $past(wdata));

endmodule

// File: rtl/sysctl_setclr.sv
module sysctl_setclr #(
   parameter int unsigned W = 32,
   parameter logic [W-1:0] RST = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_we,
   input  logic         clr_we,
   input  logic [W-1:0] mask,
   output logic [W-1:0] q
);

   always_ff @(posedge clk) begin
      if (!rst_n)      q <= RST;
      else if (set_we) q <= q | mask;
      else if (clr_we) q <= q & ~mask;
   end

   // R5: a clear leaves none of the written bits standing
   p_clear_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && !set_we) |=> ((q & $past(mask)) == '0));

endmodule

// File: rtl/sysctl_irq.sv
module sysctl_irq #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] raw,
   input  logic [W-1:0] irq_en,
   input  logic [W-1:0] fiq_en,
   output logic         irq_o,
   output logic         fiq_o
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_o <= 1'b0;
         fiq_o <= 1'b0;
      end else begin
         irq_o <= |(raw & irq_en);
         fiq_o <= |(raw & fiq_en);
      end
   end

   // R10: no request without a pending raw bit one cycle earlier
   p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(raw == '0) |-> (!irq_o && !fiq_o));

endmodule

// File: rtl/sysctl_bank.sv
module sysctl_bank
   import sysctl_pkg::*;
#(
   parameter int unsigned ADDR_W = 7,
   parameter int unsigned MEM_MB = 128,
   parameter int unsigned KEY_W  = 16,
   parameter logic [KEY_W-1:0] UNLOCK_KEY = 16'hA05F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_widx,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              bus_err,
   output logic              remap_o,
   output logic              led_o,
   output logic              board_rst_o,
   output logic              irq_o,
   output logic              fiq_o
);

   localparam logic [31:0] SDCFG_RST = SDCFG_BASE | size_code(MEM_MB);
   localparam int unsigned CTRL_RST_BIT = 3;

   if (ADDR_W < 7) begin : g_bad_addr
      $error("sysctl_bank: ADDR_W must reach the SPD window");
   end
   if (KEY_W > 16 || KEY_W == 0) begin : g_bad_key
      $error("sysctl_bank: KEY_W must be 1..16");
   end

   logic [31:0] widx;
   logic        wr, rd;
   assign widx = 32'(bus_widx);
   assign wr   = bus_sel &  bus_wr;
   assign rd   = bus_sel & ~bus_wr;

   // lock key
   logic [KEY_W-1:0] key_q;
   logic             unlocked;
   sysctl_lock #(.KEY_W(KEY_W), .KEY(UNLOCK_KEY)) u_lock (
      .clk(clk), .rst_n(rst_n),
      .we(wr && widx == IX_LOCK), .wdata(bus_wdata[KEY_W-1:0]),
      .key_q(key_q), .unlocked(unlocked));

   // set/clear words: flags, non-volatile flags, IRQ and FIQ enables
   localparam int unsigned SET_IX [N_SC] = '{IX_FLG_SET, IX_NVF_SET, IX_IEN_SET, IX_FEN_SET};
   localparam int unsigned CLR_IX [N_SC] = '{IX_FLG_CLR, IX_NVF_CLR, IX_IEN_CLR, IX_FEN_CLR};
   logic [31:0] sc_q [N_SC];
   for (genvar g = 0; g < N_SC; g++) begin : g_sc
      sysctl_setclr #(.W(32), .RST('0)) u_sc (
         .clk(clk), .rst_n(rst_n),
         .set_we(wr && widx == SET_IX[g]), .clr_we(wr && widx == CLR_IX[g]),
         .mask(bus_wdata), .q(sc_q[g]));
   end

   // software interrupt bit, the only live raw bit
   logic        soft_q;
   logic [31:0] raw;
   sysctl_setclr #(.W(1), .RST(1'b0)) u_soft (
      .clk(clk), .rst_n(rst_n),
      .set_we(wr && widx == IX_SW_SET && bus_wdata[0]),
      .clr_we(wr && widx == IX_SW_CLR && bus_wdata[0]),
      .mask(1'b1), .q(soft_q));
   assign raw = {31'b0, soft_q};

   sysctl_irq #(.W(32)) u_irq (
      .clk(clk), .rst_n(rst_n), .raw(raw),
      .irq_en(sc_q[SC_IEN]), .fiq_en(sc_q[SC_FEN]),
      .irq_o(irq_o), .fiq_o(fiq_o));

   // plain storage words
   logic [31:0] osc_q, aux_q, sdcfg_q, init_q, ctrl_q;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         osc_q       <= OSC_RST;
         aux_q       <= AUXOSC_RST;
         sdcfg_q     <= SDCFG_RST;
         init_q      <= INIT_RST;
         ctrl_q      <= '0;
         board_rst_o <= 1'b0;
      end else begin
         board_rst_o <= wr && widx == IX_CTRL && bus_wdata[CTRL_RST_BIT];
         if (wr && widx == IX_OSC && unlocked)    osc_q   <= bus_wdata;
         if (wr && widx == IX_AUXOSC && unlocked) aux_q   <= bus_wdata;
         if (wr && widx == IX_SDCFG)              sdcfg_q <= bus_wdata;
         if (wr && widx == IX_INIT)               init_q  <= bus_wdata;
         if (wr && widx == IX_CTRL) begin
            ctrl_q <= bus_wdata;
            ctrl_q[CTRL_RST_BIT] <= 1'b0;
         end
      end
   end
   assign remap_o = ~ctrl_q[2];
   assign led_o   =  ctrl_q[0];

   // read decode
   logic [31:0] rd_val;
   logic        rd_ok;
   always_comb begin
      rd_val = '0;
      rd_ok  = 1'b1;
      case (widx)
         IX_IDENT:   rd_val = IDENT_WORD;
         IX_CPUINFO: rd_val = '0;
         IX_OSC:     rd_val = osc_q;
         IX_CTRL:    rd_val = ctrl_q;
         IX_STAT:    rd_val = STAT_WORD;
         IX_LOCK:    rd_val = unlocked ? UNLOCK_RD : 32'(key_q);
         IX_AUXOSC:  rd_val = aux_q;
         IX_SDCFG:   rd_val = sdcfg_q;
         IX_INIT:    rd_val = init_q;
         IX_FLG_SET: rd_val = sc_q[SC_FLG];
         IX_NVF_SET: rd_val = sc_q[SC_NVF];
         IX_IRQ_ST:  rd_val = raw & sc_q[SC_IEN];
         IX_RAW_A,
         IX_RAW_B:   rd_val = raw;
         IX_IEN_SET: rd_val = sc_q[SC_IEN];
         IX_SW_SET:  rd_val = {31'b0, raw[0]};
         IX_FIQ_ST:  rd_val = raw & sc_q[SC_FEN];
         IX_FEN_SET: rd_val = sc_q[SC_FEN];
         default: begin
            if (widx >= IX_VOLT_LO && widx <= IX_VOLT_HI)
               rd_val = '0;
            else if (widx >= IX_SPD_LO && widx < IX_SPD_LO + SPD_USED)
               rd_val = {24'b0, spd_byte(widx - IX_SPD_LO, MEM_MB)};
            else if (widx >= IX_SPD_LO && widx <= IX_SPD_HI)
               rd_val = '0;
            else
               rd_ok = 1'b0;
         end
      endcase
   end

   // write decode: which indices accept a write
   logic wr_ok;
   always_comb begin
      case (widx)
         IX_OSC, IX_CTRL, IX_LOCK, IX_AUXOSC, IX_SDCFG, IX_INIT,
         IX_FLG_SET, IX_FLG_CLR, IX_NVF_SET, IX_NVF_CLR,
         IX_IEN_SET, IX_IEN_CLR, IX_SW_SET, IX_SW_CLR,
         IX_FEN_SET, IX_FEN_CLR: wr_ok = 1'b1;
         default: wr_ok = (widx >= IX_VOLT_LO && widx <= IX_VOLT_HI);
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rdata <= '0;
         bus_err   <= 1'b0;
      end else begin
         bus_err <= (rd && !rd_ok) || (wr && !wr_ok);
         if (rd) bus_rdata <= rd_ok ? rd_val : '0;
      end
   end

   // R3: a locked bank keeps both oscillator words
   p_osc_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && widx == IX_OSC && !unlocked) |=> $stable(osc_q));
   p_aux_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && widx == IX_AUXOSC && !unlocked) |=> $stable(aux_q));
   // R12: an erroring read returns zero
   p_err_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_err && $past(rd)) |-> bus_rdata == '0);
   // R7: the reset request never lasts into a cycle without a new request
   p_rst_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (board_rst_o && !(wr && widx == IX_CTRL)) |=> !board_rst_o);

endmodule

// File: tb/sim_sysctl_bank.sv
`timescale 1ns/1ps
module sim_sysctl_bank;
   localparam int unsigned AW  = 7;
   localparam int unsigned MEM = 128;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_sel = 1'b0, bus_wr = 1'b0;
   logic [AW-1:0] bus_widx = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          bus_err, remap_o, led_o, board_rst_o, irq_o, fiq_o;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   sysctl_bank #(.ADDR_W(AW), .MEM_MB(MEM)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_widx(bus_widx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_err(bus_err), .remap_o(remap_o), .led_o(led_o),
      .board_rst_o(board_rst_o), .irq_o(irq_o), .fiq_o(fiq_o));

   function automatic logic [31:0] exp_code(int unsigned mb);
      if (mb >= 256) return 32'h10;
      if (mb >= 128) return 32'h0C;
      if (mb >= 64)  return 32'h08;
      if (mb >= 32)  return 32'h04;
      return 32'h0;
   endfunction
   function automatic logic [31:0] exp_spd31(int unsigned mb);
      if (mb >= 256) return 64;
      if (mb >= 128) return 32;
      if (mb >= 64)  return 16;
      if (mb >= 32)  return 4;
      return 2;
   endfunction

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s got=0x%08h exp=0x%08h", tag, got, exp);
      end
   endtask

   task automatic wr(input int idx, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_widx = AW'(idx); bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input int idx, output logic [31:0] d, output logic e);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_widx = AW'(idx);
      @(negedge clk);
      bus_sel = 1'b0;
      d = bus_rdata; e = bus_err;
   endtask

   task automatic rd_chk(input string tag, input int idx, input logic [31:0] exp);
      logic [31:0] d; logic e;
      rd(idx, d, e);
      check(tag, d, exp);
   endtask

   task automatic t_reset;
      check("R7 reset remap", 32'(remap_o), 1);
      check("R7 reset led", 32'(led_o), 0);
      check("R7 reset board_rst", 32'(board_rst_o), 0);
      check("R10 reset irq/fiq", {30'b0, irq_o, fiq_o}, 0);
      check("R12 reset err", 32'(bus_err), 0);
      rd_chk("R4 osc reset", 2, 32'h0100_0048);
      rd_chk("R4 aux reset", 7, 32'h0007_FEFF);
      rd_chk("R4 sdram reset", 8, 32'h0001_1122 | exp_code(MEM));
      rd_chk("R4 init reset", 9, 32'h0000_0112);
      rd_chk("R5 flags reset", 12, 0);
   endtask

   task automatic t_ident;
      logic [31:0] d; logic e;
      rd(0, d, e);
      check("R1 ident", d, 32'h411A_3001);
      check("R1 ident err", 32'(e), 0);
      rd_chk("R1 status", 4, 32'h0010_0000);
      rd_chk("R1 cpuinfo", 1, 0);
      // R1: value held until the next read
      @(negedge clk); @(negedge clk);
      check("R1 rdata held", bus_rdata, 0);
   endtask

   task automatic t_lock_osc;
      rd_chk("R2 lock reset", 5, 0);
      wr(5, 32'h1234_5678);
      rd_chk("R2 low half only", 5, 32'h0000_5678);
      wr(2, 32'hDEAD_BEEF);
      wr(7, 32'hCAFE_F00D);
      rd_chk("R3 osc locked", 2, 32'h0100_0048);
      rd_chk("R3 aux locked", 7, 32'h0007_FEFF);
      wr(5, 32'hFFFF_A05F);
      rd_chk("R2 unlocked readback", 5, 32'h0001_A05F);
      wr(2, 32'h0000_0011);
      wr(7, 32'h0000_0022);
      rd_chk("R3 osc unlocked", 2, 32'h11);
      rd_chk("R3 aux unlocked", 7, 32'h22);
      wr(5, 0);
      wr(2, 32'h0000_0099);
      rd_chk("R3 osc relocked", 2, 32'h11);
   endtask

   task automatic t_sdram_init;
      wr(8, 32'h0000_ABCD);
      rd_chk("R4 sdram write", 8, 32'h0000_ABCD);
      wr(9, 32'h0000_0005);
      rd_chk("R4 init write", 9, 32'h5);
   endtask

   task automatic t_flags;
      wr(12, 32'hF0); wr(12, 32'h0F);
      rd_chk("R5 flags set", 12, 32'hFF);
      wr(13, 32'h3C);
      rd_chk("R5 flags clear", 12, 32'hC3);
      wr(14, 32'h8000_0001); wr(15, 32'h1);
      rd_chk("R5 nvflags", 14, 32'h8000_0000);
      rd_chk("R5 flags untouched", 12, 32'hC3);
   endtask

   task automatic t_spd;
      rd_chk("R6 spd byte0", 64, 128);
      rd_chk("R6 spd byte2", 66, 4);
      rd_chk("R6 spd byte31", 95, exp_spd31(MEM));
      rd_chk("R6 spd above", 96, 0);
      rd_chk("R6 spd top", 127, 0);
   endtask

   task automatic t_ctrl;
      wr(3, 32'h0000_000D);
      check("R7 board_rst pulse", 32'(board_rst_o), 1);
      check("R7 led on", 32'(led_o), 1);
      check("R7 remap off", 32'(remap_o), 0);
      @(negedge clk);
      check("R7 board_rst ends", 32'(board_rst_o), 0);
      rd_chk("R7 bit3 not stored", 3, 32'h5);
      wr(3, 0);
      check("R7 remap back", 32'(remap_o), 1);
      check("R7 led off", 32'(led_o), 0);
      check("R7 no pulse", 32'(board_rst_o), 0);
   endtask

   task automatic t_irq;
      wr(18, 32'h1);
      rd_chk("R9 irq enable read", 18, 32'h1);
      wr(20, 32'h1);
      check("R10 irq not yet", 32'(irq_o), 0);
      @(negedge clk);
      check("R10 irq raised", 32'(irq_o), 1);
      check("R10 fiq idle", 32'(fiq_o), 0);
      rd_chk("R9 irq status", 16, 1);
      rd_chk("R8 raw A", 17, 1);
      rd_chk("R9 fiq status masked", 24, 0);
      rd_chk("R8 soft read", 20, 1);
      wr(26, 32'h1);
      @(negedge clk);
      check("R10 fiq raised", 32'(fiq_o), 1);
      wr(19, 32'h1);
      @(negedge clk);
      check("R10 irq dropped", 32'(irq_o), 0);
      rd_chk("R9 irq enable cleared", 18, 0);
      wr(21, 32'h2);
      rd_chk("R8 clear needs bit0", 25, 1);
      wr(21, 32'h1);
      @(negedge clk);
      check("R10 fiq dropped", 32'(fiq_o), 0);
      rd_chk("R8 raw B", 25, 0);
      wr(20, 32'hFFFF_FFFE);
      rd_chk("R8 set needs bit0", 17, 0);
   endtask

   task automatic t_volt;
      logic [31:0] d; logic e;
      wr(33, 32'hFFFF_FFFF);
      check("R11 volt write err", 32'(bus_err), 0);
      rd(33, d, e);
      check("R11 volt read", d, 0);
      check("R11 volt err", 32'(e), 0);
   endtask

   task automatic t_unmapped;
      logic [31:0] d; logic e;
      rd(0, d, e);
      rd(6, d, e);
      check("R12 read data zero", d, 0);
      check("R12 read err", 32'(e), 1);
      @(negedge clk);
      check("R12 err one cycle", 32'(bus_err), 0);
      wr(0, 32'h0);
      check("R12 write ro err", 32'(bus_err), 1);
      rd_chk("R12 ident unchanged", 0, 32'h411A_3001);
      wr(11, 32'hFF);
      check("R12 write hole err", 32'(bus_err), 1);
      rd_chk("R12 flags unchanged", 12, 32'hC3);
      rd(13, d, e);
      check("R12 read clear index err", 32'(e), 1);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ident();
      t_lock_osc();
      t_sdram_init();
      t_flags();
      t_spd();
      t_ctrl();
      t_irq();
      t_volt();
      t_unmapped();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule